// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits beside a two-port memory array. It resolves same-location collisions between the ports, called A and B. Every clock cycle it looks at both ports' enables and addresses. When both ports are enabled on the same address, one port is allowed to proceed. The other port is flagged busy, and any write it attempts is blocked before it reaches the array.

The port that was already sitting on the address keeps the location. Once a winner is picked, the decision stays fixed for as long as the collision lasts. If both ports arrive in the same cycle, a tie rule decides: either the left port (A) always wins, or the winner alternates from one tie to the next.

In slave mode the block does no arbitration of its own. Its busy inputs come from a single master arbiter, and it uses them only to block writes. This lets several arrays placed side by side to widen the data word all follow the same decision.

Top module: `busy_arb`

## Requirements
- R1: Both busy outputs stay 0 whenever either port's enable is 0 or the two addresses differ.
- R2: The busy outputs depend only on the enables, the addresses and the arbitration history; the write strobes have no effect on them.
- R3: A port is *established* when it had its enable at 1 on the same address in the previous cycle. On a new collision, if exactly one port is established, the other port gets busy.
- R4: busy_out_a and busy_out_b are never 1 together.
- R5: With tie_toggle=0, a new collision in which neither port (or both ports) is established gives busy to port B.
- R6: With tie_toggle=1, such ties alternate. The first tie after reset gives busy to B, the next gives busy to A, and so on; only ties decided in toggle mode advance the rotation.
- R7: While a collision persists from cycle to cycle, the busy port does not change.
- R8: Busy drops in the same cycle the addresses stop matching or an enable goes to 0.
- R9: In master mode (slave_mode=0), we_out_x = we_x AND ce_x AND NOT busy_out_x.
- R10: In slave mode (slave_mode=1), both busy outputs are 0, there is no arbitration, and we_out_x = we_x AND ce_x AND NOT busy_in_x.
- R11: Busy and the gated writes follow the current cycle's inputs with no added register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1: busy comes in on busy_in_x and is used only to block writes |
| tie_toggle | input | 1 | Tie rule: 0 = port A wins, 1 = alternating |
| ce_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write strobe |
| addr_a | input | AW | Port A address |
| busy_in_a | input | 1 | Port A write block from a master (slave mode) |
| ce_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write strobe |
| addr_b | input | AW | Port B address |
| busy_in_b | input | 1 | Port B write block from a master (slave mode) |
| busy_out_a | output | 1 | Port A lost the collision |
| busy_out_b | output | 1 | Port B lost the collision |
| we_out_a | output | 1 | Port A write after gating, to the array |
| we_out_b | output | 1 | Port B write after gating, to the array |

## Verification
The main overlap is a write strobe on a port arriving in the same cycle as the collision that makes that port busy. The gating has to use the busy decision of that very cycle. The bench provokes this by raising the late port's enable, its matching address and its write strobe together, then checks that the gated write stays low while the winner's write passes. Simultaneous arrival and the release of a held collision are also swept against a cycle model in the bench, built from the requirements, over a two-bit address space so that collisions are frequent.

// File: rtl/busy_arb.sv
module busy_arb #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          tie_toggle,
  input  logic          ce_a,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic          busy_in_a,
  input  logic          ce_b,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic          busy_in_b,
  output logic          busy_out_a,
  output logic          busy_out_b,
  output logic          we_out_a,
  output logic          we_out_b
);

  logic          ce_a_q, ce_b_q;
  logic [AW-1:0] addr_a_q, addr_b_q;
  logic          hit_q, own_a_q, tie_q;

  logic hit, a_est, b_est, tie_case, win_a;

  assign hit      = ~slave_mode & ce_a & ce_b & (addr_a == addr_b);
  assign a_est    = ce_a_q & (addr_a_q == addr_a);
  assign b_est    = ce_b_q & (addr_b_q == addr_b);
  assign tie_case = ~hit_q & (a_est == b_est);

  always_comb begin
    if (hit_q)               win_a = own_a_q;
    else if (a_est & ~b_est) win_a = 1'b1;
    else if (b_est & ~a_est) win_a = 1'b0;
    else                     win_a = ~tie_toggle | ~tie_q;
  end

  assign busy_out_b = hit & win_a;
  assign busy_out_a = hit & ~win_a;

  assign we_out_a = we_a & ce_a & ~(slave_mode ? busy_in_a : busy_out_a);
  assign we_out_b = we_b & ce_b & ~(slave_mode ? busy_in_b : busy_out_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_a_q   <= 1'b0;
      ce_b_q   <= 1'b0;
      addr_a_q <= '0;
      addr_b_q <= '0;
      hit_q    <= 1'b0;
      own_a_q  <= 1'b0;
      tie_q    <= 1'b0;
    end else begin
      ce_a_q   <= ce_a;
      ce_b_q   <= ce_b;
      addr_a_q <= addr_a;
      addr_b_q <= addr_b;
      hit_q    <= hit;
      if (hit) own_a_q <= win_a;
      if (hit & tie_case & tie_toggle) tie_q <= ~tie_q;
    end
  end

  assert_never_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_out_a && busy_out_b));

  assert_idle_no_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_a || !ce_b || addr_a != addr_b) |-> (!busy_out_a && !busy_out_b));

  assert_hold_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_out_b |=> (!busy_out_a));

  assert_hold_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_out_a |=> (!busy_out_b));

  assert_gate_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && busy_out_a) |-> !we_out_a);

  assert_gate_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && busy_out_b) |-> !we_out_b);

  assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (!busy_out_a && !busy_out_b));

  assert_slave_inhibit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && (busy_in_a || busy_in_b)) |-> !((busy_in_a && we_out_a) || (busy_in_b && we_out_b)));

endmodule

// File: tb/busy_arb_tb.sv
module busy_arb_tb_top;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slv = 1'b0, tt = 1'b0;
  logic ca = 1'b0, wa = 1'b0, bia = 1'b0, cb = 1'b0, wb = 1'b0, bib = 1'b0;
  logic [AW-1:0] aa = '0, ab = '0;
  logic boa, bob, woa, wob;

  int checks = 0, fails = 0;

  // bench model state
  logic m_ca, m_cb, m_hit, m_owna, m_tie;
  logic [AW-1:0] m_aa, m_ab;
  logic e_boa, e_bob, e_woa, e_wob, e_hit, e_wina, e_tie;

  always #4 clk = ~clk;

  busy_arb #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .slave_mode(slv), .tie_toggle(tt),
    .ce_a(ca), .we_a(wa), .addr_a(aa), .busy_in_a(bia),
    .ce_b(cb), .we_b(wb), .addr_b(ab), .busy_in_b(bib),
    .busy_out_a(boa), .busy_out_b(bob), .we_out_a(woa), .we_out_b(wob));

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_eval;
    logic ae, be;
    e_hit = !slv && ca && cb && (aa == ab);
    ae = m_ca && (m_aa == aa);
    be = m_cb && (m_ab == ab);
    e_tie = !m_hit && (ae == be);
    if (m_hit)          e_wina = m_owna;
    else if (ae && !be) e_wina = 1'b1;
    else if (be && !ae) e_wina = 1'b0;
    else                e_wina = !tt || !m_tie;
    e_bob = e_hit && e_wina;
    e_boa = e_hit && !e_wina;
    e_woa = wa && ca && !(slv ? bia : e_boa);
    e_wob = wb && cb && !(slv ? bib : e_bob);
  endtask

  task automatic model_update;
    if (e_hit && e_tie && tt) m_tie = !m_tie;
    if (e_hit) m_owna = e_wina;
    m_hit = e_hit;
    m_ca = ca; m_cb = cb; m_aa = aa; m_ab = ab;
  endtask

  // drive at posedge+1, sample at +4, clock edge at +8
  task automatic step(input logic a_ce, input logic [AW-1:0] a_ad, input logic a_we,
                      input logic b_ce, input logic [AW-1:0] b_ad, input logic b_we);
    string tag;
    ca = a_ce; aa = a_ad; wa = a_we; cb = b_ce; ab = b_ad; wb = b_we;
    #3;
    model_eval();
    tag = slv ? "R10" : (!e_hit ? "R1" : "R3");
    chk({tag, " busy_out_a"}, boa, e_boa);
    chk({tag, " busy_out_b"}, bob, e_bob);
    chk({tag, " we_out_a"}, woa, e_woa);
    chk({tag, " we_out_b"}, wob, e_wob);
    @(posedge clk);
    model_update();
    #1;
  endtask

  initial begin
    m_ca = 0; m_cb = 0; m_aa = '0; m_ab = '0; m_hit = 0; m_owna = 0; m_tie = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("reset R1 busy_out_a", boa, 1'b0);
    chk("reset R1 busy_out_b", bob, 1'b0);
    chk("reset R9 we_out_a", woa, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: single port and differing addresses
    step(1, 2'd1, 1, 0, 2'd1, 1); chk("R1 lone A no busy", bob, 0); chk("R9 A write passes", woa, 1);
    step(1, 2'd1, 1, 1, 2'd2, 1); chk("R1 diff addr", boa | bob, 0); chk("R9 B write passes", wob, 1);
    step(0, 2'd0, 0, 0, 2'd0, 0);

    // R3/R11: A established, B arrives with a write in the same cycle
    step(1, 2'd3, 0, 0, 2'd0, 0);
    step(1, 2'd3, 1, 1, 2'd3, 1);
    chk("R3 late B busy", bob, 1); chk("R11 B write gated same cycle", wob, 0);
    chk("R9 winner A writes", woa, 1);
    // R7 hold, R2 write strobes have no effect
    step(1, 2'd3, 0, 1, 2'd3, 0); chk("R7 hold busy B", bob, 1); chk("R2 strobe ignored", boa, 0);
    step(1, 2'd3, 1, 1, 2'd3, 1); chk("R7 hold busy B again", bob, 1);
    // R8 release
    step(1, 2'd2, 1, 1, 2'd3, 1); chk("R8 release on addr change", bob, 0); chk("R8 B writes again", wob, 1);
    step(0, 2'd0, 0, 0, 2'd0, 0);

    // R3 mirrored: B established
    step(0, 2'd0, 0, 1, 2'd1, 0);
    step(1, 2'd1, 1, 1, 2'd1, 0); chk("R3 late A busy", boa, 1); chk("R9 A write gated", woa, 0);
    step(0, 2'd1, 0, 1, 2'd1, 0); chk("R8 release on enable low", boa, 0);
    step(0, 2'd0, 0, 0, 2'd0, 0);

    // R5 fixed-left ties
    tt = 0;
    step(1, 2'd2, 0, 1, 2'd2, 0); chk("R5 tie B busy", bob, 1); chk("R4 one busy", boa, 0);
    step(0, 2'd0, 0, 0, 2'd0, 0);
    step(1, 2'd0, 0, 1, 2'd0, 0); chk("R5 tie B busy again", bob, 1);
    step(0, 2'd0, 0, 0, 2'd0, 0);

    // R6 toggling ties
    tt = 1;
    step(1, 2'd1, 0, 1, 2'd1, 0); chk("R6 first tie B busy", bob, 1);
    step(0, 2'd0, 0, 0, 2'd0, 0);
    step(1, 2'd1, 0, 1, 2'd1, 0); chk("R6 second tie A busy", boa, 1);
    step(0, 2'd0, 0, 0, 2'd0, 0);
    step(1, 2'd2, 0, 1, 2'd2, 0); chk("R6 third tie B busy", bob, 1);
    step(0, 2'd0, 0, 0, 2'd0, 0);
    tt = 0;

    // R10 slave mode
    slv = 1; bia = 1; bib = 0;
    step(1, 2'd3, 1, 1, 2'd3, 1);
    chk("R10 no busy out", boa | bob, 0); chk("R10 A blocked by input", woa, 0);
    chk("R10 B writes", wob, 1);
    bia = 0; bib = 1;
    step(1, 2'd3, 1, 1, 2'd3, 1);
    chk("R10 A writes", woa, 1); chk("R10 B blocked by input", wob, 0);
    slv = 0; bia = 0; bib = 0;
    step(0, 2'd0, 0, 0, 2'd0, 0);

    // near-exhaustive sweep with bench model
    for (int i = 0; i < 6000; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      if (i % 97 == 0) tt = ~tt;
      if (i % 251 == 0) slv = ~slv;
      bia = r[8]; bib = r[9];
      step(r[0] | r[1], r[3:2], r[4], r[5] | r[1], r[7:6], r[4] ^ r[0]);
      chk("R4 exclusive busy", boa & bob, 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule